// File: doc/BRIEF.md
# USB Transmit Serializer with Bit Stuffing

This block turns a stream of bytes from a UTMI-style transmit port into one USB packet on a D+/D- line pair. When the first byte is accepted it sends the synchronisation byte. It then shifts out every payload byte least significant bit first. A zero is inserted after each run of six ones, and the stream is NRZI-coded onto the pair. When the link side stops offering bytes, the block closes the packet with an end-of-packet sequence and releases the driver.

The serial side advances one bit time per cycle on which the bit-rate enable `bit_en` is high. The parallel side uses a ready/valid handshake with a one-byte holding register. The handshake stalls while a stuffed bit is pending, so the link side never runs ahead of the line. A two-bit mode input, sampled when a packet starts, selects one of three behaviours. Normal mode stuffs and encodes. No-driver mode keeps the output-enable low. Raw mode sends the bits without stuffing or NRZI.

Top module: `usb_tx_serializer`

## Requirements
- R1: A byte is taken from `tx_data` only on a clock edge where `tx_valid` and `tx_ready` are both high. Every taken byte appears on the line exactly once, in the order taken.
- R2: `tx_ready` is high in idle. Inside a packet it is high only while the holding register is empty. It stays low from the bit time in which a run of six ones completes until the stuffed zero has been sent.
- R3: Every packet starts with eight synchronisation bits before encoding: seven zeros, then a one. Each payload byte then follows, bit 0 first.
- R4: In stuffing modes, a zero is inserted into the pre-encoding stream after every six consecutive ones. The synchronisation bits count toward the run. This includes a run that ends on the last payload bit, in which case the zero comes before end-of-packet.
- R5: NRZI coding toggles the line level for a 0 and holds it for a 1. The level is J at the start of each packet. J is `line_dp`=1, `line_dm`=0. K is `line_dp`=0, `line_dm`=1.
- R6: The packet ends at the first bit time that finds no byte left and no stuffed bit pending. The block then sends two bit times of SE0 (both lines 0) and one bit time of J, all with `line_oe`=1. At the next bit time it drops `line_oe` and returns to idle with `tx_ready` high.
- R7: Mode 2'b00 is normal operation. The reserved mode 2'b11 behaves identically to it.
- R8: In mode 2'b01, `line_oe` stays low for the whole packet and both lines hold J. The stuffing and handshake timing is unchanged.
- R9: In mode 2'b10, stuffing and NRZI are both off. Each pre-encoding 1 is sent as J and each 0 as K, the synchronisation bits included.
- R10: `op_mode` is sampled only when the first byte of a packet is taken. Changes during the packet have no effect.
- R11: The line outputs change only on edges where `bit_en` is high, and each such edge inside a packet advances exactly one bit time.
- R12: After reset, `line_dp`=1, `line_dm`=0, `line_oe`=0 and `tx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable; one bit time per high cycle |
| tx_data | input | BYTE_W | Byte offered by the link side |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Block can take a byte this cycle |
| op_mode | input | 2 | 00 normal, 01 driver off, 10 raw, 11 as normal |
| line_dp | output | 1 | D+ line level |
| line_dm | output | 1 | D- line level |
| line_oe | output | 1 | Line driver enable |

## Verification
Assertions check on every cycle the following properties. SE1 never appears on the pair. SE0 is seen only in the end-of-packet states. The line is never driven in idle or in no-driver mode. The outputs stay still between bit-rate enables. The sampled mode stays frozen during a packet. The ones-run counter never passes its limit, and it clears once the stuffed bit is out. No byte is ever taken into an occupied holding register. Only the bench's scenarios can show that the complete bit sequence on the pair is correct: synchronisation, payload order, stuffed-bit positions including one just before end-of-packet, NRZI levels and the raw-mode mapping. They also show that `tx_ready` is low in the cycle before each stuffed bit, and that changes to the mode in mid-packet are ignored.

// File: rtl/usb_tx_pkg.sv
// Shared types for the USB transmit serializer.
// Assumes: mode encodings are fixed by the transceiver interface.
package usb_tx_pkg;

    typedef enum logic [1:0] {
        OPM_NORMAL  = 2'b00,
        OPM_NODRIVE = 2'b01,
        OPM_RAW     = 2'b10,
        OPM_RSVD    = 2'b11
    } opmode_e;

    typedef enum logic [1:0] {
        LS_BIT,
        LS_SE0,
        LS_J,
        LS_OFF
    } slot_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_EOP_SE0,
        ST_EOP_J,
        ST_EOP_REL
    } tx_state_e;

endpackage

// File: rtl/usb_tx_byte_feed.sv
// Byte feed: one-byte holding register plus a shift register emitting LSB first.
// On start the shifter is preloaded with the sync pattern and the first byte is held.
// Assumes: accept is asserted only when the holding register is empty.
module usb_tx_byte_feed #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              accept,
    input  logic [BYTE_W-1:0] din,
    input  logic              take,
    output logic              cur_bit,
    output logic              hold_full,
    output logic              empty
);

    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] SYNC_PAT = {1'b1, {(BYTE_W-1){1'b0}}};

    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] hold;
    logic [IDX_W-1:0]  idx;
    logic              need_byte;

    assign need_byte = take && (idx == LAST_IDX);
    assign cur_bit   = shreg[0];

    // Shift, reload from the holding register, or mark the stream exhausted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            hold      <= '0;
            idx       <= '0;
            hold_full <= 1'b0;
            empty     <= 1'b0;
        end else if (start) begin
            shreg     <= SYNC_PAT;
            hold      <= din;
            idx       <= '0;
            hold_full <= 1'b1;
            empty     <= 1'b0;
        end else if (need_byte) begin
            idx <= '0;
            if (hold_full) begin
                shreg     <= hold;
                hold_full <= accept;
                if (accept) begin
                    hold <= din;
                end
            end else if (accept) begin
                shreg <= din;
            end else begin
                empty <= 1'b1;
            end
        end else begin
            if (take) begin
                shreg <= shreg >> 1;
                idx   <= idx + 1'b1;
            end
            if (accept) begin
                hold      <= din;
                hold_full <= 1'b1;
            end
        end
    end

    // R1: a byte is never taken into an occupied holding register
    p_accept_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !hold_full);

    // R6: once exhausted, no further bit is consumed
    p_empty_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !start) |=> (empty || $past(start)));

endmodule

// File: rtl/usb_tx_stuffer.sv
// Bit stuffer: counts consecutive ones in the pre-encoding stream and inserts
// a zero after ONES_MAX of them. While the zero is pending, the source is held.
// Assumes: stuff_en is stable for the duration of a packet.
module usb_tx_stuffer #(
    parameter int ONES_MAX = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic slot_en,
    input  logic stuff_en,
    input  logic src_empty,
    input  logic data_bit,
    output logic stuff_now,
    output logic take,
    output logic out_bit
);

    localparam int CNT_W = $clog2(ONES_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(ONES_MAX);

    logic [CNT_W-1:0] ones_cnt;

    assign stuff_now = stuff_en && (ones_cnt == CNT_LIMIT);
    assign take      = slot_en && !stuff_now && !src_empty;
    assign out_bit   = stuff_now ? 1'b0 : data_bit;

    // Track the run of ones; restart it after a zero or an inserted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_cnt <= '0;
        end else if (clear) begin
            ones_cnt <= '0;
        end else if (slot_en) begin
            if (stuff_now) begin
                ones_cnt <= '0;
            end else if (!src_empty) begin
                ones_cnt <= (data_bit && stuff_en) ? ones_cnt + 1'b1 : '0;
            end
        end
    end

    // R4: the run counter never exceeds its limit
    p_run_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= CNT_LIMIT);

    // R4: the inserted zero restarts the run
    p_stuff_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && stuff_now && !clear) |=> (ones_cnt == '0));

endmodule

// File: rtl/usb_tx_nrzi.sv
// NRZI encoder and line register: drives D+/D- and output-enable for one bit time
// per slot. The level restarts at J at packet start. J is dp=1, dm=0.
// Assumes: kind and bit_in are valid in any cycle where slot_en is high.
module usb_tx_nrzi
    import usb_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       slot_en,
    input  slot_kind_e kind,
    input  logic       bit_in,
    input  logic       nrzi_en,
    input  logic       drive_en,
    output logic       line_dp,
    output logic       line_dm,
    output logic       line_oe
);

    logic level;
    logic next_level;

    // Next level: toggle on zero when encoding, else follow the raw bit.
    always_comb begin
        if (nrzi_en) begin
            next_level = bit_in ? level : ~level;
        end else begin
            next_level = bit_in;
        end
    end

    // Register line levels once per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b1;
            line_dp <= 1'b1;
            line_dm <= 1'b0;
            line_oe <= 1'b0;
        end else if (start) begin
            level <= 1'b1;
        end else if (slot_en) begin
            unique case (kind)
                LS_BIT: begin
                    level   <= next_level;
                    line_dp <= drive_en ? next_level : 1'b1;
                    line_dm <= drive_en ? ~next_level : 1'b0;
                    line_oe <= drive_en;
                end
                LS_SE0: begin
                    line_dp <= drive_en ? 1'b0 : 1'b1;
                    line_dm <= 1'b0;
                    line_oe <= drive_en;
                end
                LS_J: begin
                    line_dp <= 1'b1;
                    line_dm <= 1'b0;
                    line_oe <= drive_en;
                end
                default: begin
                    line_dp <= 1'b1;
                    line_dm <= 1'b0;
                    line_oe <= 1'b0;
                end
            endcase
        end
    end

    // R5: both lines high never appears
    p_no_se1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_dp && line_dm));

    // R11: outputs hold between bit-rate enables
    p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable({line_dp, line_dm, line_oe}));

    // R6: the release slot drops the driver
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && !start && kind == LS_OFF) |=> !line_oe);

endmodule

// File: rtl/usb_tx_serializer.sv
// USB transmit serializer top: packet sequencing (sync, payload, stuffing,
// end-of-packet), byte handshake and mode handling.
// Assumes: bit_en marks one serial bit time; op_mode is sampled at packet start.
module usb_tx_serializer
    import usb_tx_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int ONES_MAX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [1:0]        op_mode,
    output logic              line_dp,
    output logic              line_dm,
    output logic              line_oe
);

    tx_state_e  state;
    opmode_e    mode_q;
    slot_kind_e kind;

    logic accept;
    logic start;
    logic feed_accept;
    logic active_slot;
    logic line_slot;
    logic stuff_en;
    logic drive_en;
    logic cur_bit;
    logic hold_full;
    logic feed_empty;
    logic stuff_now;
    logic take;
    logic enc_bit;

    assign accept      = tx_valid && tx_ready;
    assign start       = accept && (state == ST_IDLE);
    assign feed_accept = accept && (state == ST_ACTIVE);
    assign active_slot = bit_en && (state == ST_ACTIVE);
    assign line_slot   = bit_en && (state != ST_IDLE);
    assign stuff_en    = (mode_q != OPM_RAW);
    assign drive_en    = (mode_q != OPM_NODRIVE);

    // Ready: open in idle; in a packet only with room and no stuffed bit pending.
    always_comb begin
        unique case (state)
            ST_IDLE:   tx_ready = 1'b1;
            ST_ACTIVE: tx_ready = !hold_full && !stuff_now && !feed_empty;
            default:   tx_ready = 1'b0;
        endcase
    end

    // Select what the line carries in this bit time.
    always_comb begin
        unique case (state)
            ST_ACTIVE:  kind = (stuff_now || !feed_empty) ? LS_BIT : LS_SE0;
            ST_EOP_SE0: kind = LS_SE0;
            ST_EOP_J:   kind = LS_J;
            default:    kind = LS_OFF;
        endcase
    end

    // Packet sequencer and mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= OPM_NORMAL;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_ACTIVE;
                        mode_q <= opmode_e'(op_mode);
                    end
                end
                ST_ACTIVE: begin
                    if (bit_en && !stuff_now && feed_empty) begin
                        state <= ST_EOP_SE0;
                    end
                end
                ST_EOP_SE0: if (bit_en) state <= ST_EOP_J;
                ST_EOP_J:   if (bit_en) state <= ST_EOP_REL;
                default:    if (bit_en) state <= ST_IDLE;
            endcase
        end
    end

    usb_tx_byte_feed #(
        .BYTE_W(BYTE_W)
    ) u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .accept   (feed_accept),
        .din      (tx_data),
        .take     (take),
        .cur_bit  (cur_bit),
        .hold_full(hold_full),
        .empty    (feed_empty)
    );

    usb_tx_stuffer #(
        .ONES_MAX(ONES_MAX)
    ) u_stuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .slot_en  (active_slot),
        .stuff_en (stuff_en),
        .src_empty(feed_empty),
        .data_bit (cur_bit),
        .stuff_now(stuff_now),
        .take     (take),
        .out_bit  (enc_bit)
    );

    usb_tx_nrzi u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .slot_en (line_slot),
        .kind    (kind),
        .bit_in  (enc_bit),
        .nrzi_en (stuff_en),
        .drive_en(drive_en),
        .line_dp (line_dp),
        .line_dm (line_dm),
        .line_oe (line_oe)
    );

    // R10: the sampled mode is frozen while a packet is in flight
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mode_q));

    // R8: no-driver mode never enables the line
    p_nodrive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && mode_q == OPM_NODRIVE) |-> !line_oe);

    // R6: the driver is released whenever the block is idle
    p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !line_oe);

    // R6: SE0 appears only during end-of-packet
    p_se0_in_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_dp && !line_dm) |-> (state == ST_EOP_SE0 || state == ST_EOP_J));

endmodule

// File: tb/usb_tx_serializer_test.sv
`timescale 1ns/1ps
module usb_tx_serializer_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic [1:0] op_mode;
    logic       tx_ready;
    logic       line_dp;
    logic       line_dm;
    logic       line_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] pkt       [0:7];
    logic [2:0] exp_slot  [0:255];
    bit         exp_stuff [0:255];
    int         exp_len;

    always #2.5 clk = ~clk;

    usb_tx_serializer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .op_mode (op_mode),
        .line_dp (line_dp),
        .line_dm (line_dm),
        .line_oe (line_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Append one encoded bit time ({dp,dm,oe}) to the expected list.
    task automatic emit(input bit x, input bit s, input bit nrzi, input bit drive,
                        inout bit lvl, inout int k);
        if (nrzi) begin
            if (!x) lvl = ~lvl;
        end else begin
            lvl = x;
        end
        exp_slot[k]  = drive ? {lvl, ~lvl, 1'b1} : 3'b100;
        exp_stuff[k] = s;
        k++;
    endtask

    // Reference model from the requirements (R3 R4 R5 R6 R7 R8 R9).
    task automatic build_expected(input int n, input logic [1:0] mode);
        bit stuff_on = (mode != 2'b10);
        bit drive    = (mode != 2'b01);
        bit lvl      = 1'b1;
        int ones     = 0;
        int k        = 0;
        logic [7:0] byte_v;
        for (int b = 0; b <= n; b++) begin
            byte_v = (b == 0) ? 8'h80 : pkt[b-1];
            for (int i = 0; i < 8; i++) begin
                emit(byte_v[i], 1'b0, stuff_on, drive, lvl, k);
                if (stuff_on) begin
                    ones = byte_v[i] ? ones + 1 : 0;
                    if (ones == 6) begin
                        emit(1'b0, 1'b1, stuff_on, drive, lvl, k);
                        ones = 0;
                    end
                end
            end
        end
        for (int j = 0; j < 4; j++) begin
            exp_stuff[k] = 1'b0;
            case (j)
                0, 1:    exp_slot[k] = drive ? 3'b001 : 3'b100;
                2:       exp_slot[k] = {2'b10, drive};
                default: exp_slot[k] = 3'b100;
            endcase
            k++;
        end
        exp_len = k;
    endtask

    task automatic run_packet(input int n, input logic [1:0] mode);
        int   idx      = 0;
        int   slot     = 0;
        int   guard    = 0;
        bit   started  = 0;
        bit   acc_pend = 0;
        bit   en_prev  = 0;
        logic [2:0] prev;
        string req;
        build_expected(n, mode);
        op_mode  = mode;
        prev     = {line_dp, line_dm, line_oe};
        while (slot < exp_len && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (started) begin
                if (en_prev) begin
                    if (exp_stuff[slot])          req = "R4";
                    else if (slot < 8)            req = "R3";
                    else if (slot >= exp_len - 4) req = "R6";
                    else if (mode == 2'b01)       req = "R8";
                    else if (mode == 2'b10)       req = "R9";
                    else if (mode == 2'b11)       req = "R7";
                    else                          req = "R5";
                    check({line_dp, line_dm, line_oe} == exp_slot[slot], req,
                          "line slot", {line_dp, line_dm, line_oe}, exp_slot[slot]);
                    if (slot + 1 < exp_len && exp_stuff[slot + 1])
                        check(!tx_ready, "R2", "ready before stuffed bit", tx_ready, 0);
                    if (slot >= exp_len - 4 && slot < exp_len - 1)
                        check(!tx_ready, "R6", "ready during end of packet", tx_ready, 0);
                    if (slot == exp_len - 1) begin
                        check(tx_ready, "R6", "ready after release", tx_ready, 1);
                        check(!line_oe, "R6", "driver released", line_oe, 0);
                    end
                    slot++;
                end else begin
                    // R11: no change without a bit-rate enable
                    check({line_dp, line_dm, line_oe} == prev, "R11", "hold",
                          {line_dp, line_dm, line_oe}, prev);
                end
            end
            if (acc_pend) begin
                started = 1;
                idx++;
            end
            prev     = {line_dp, line_dm, line_oe};
            tx_valid = (idx < n);
            tx_data  = (idx < n) ? pkt[idx] : 8'($urandom);
            bit_en   = ($urandom % 4) != 0;
            if (started) op_mode = 2'($urandom);   // R10: mid-packet mode changes
            acc_pend = tx_valid && tx_ready;
            en_prev  = bit_en;
        end
        check(guard < 5000, "R6", "packet completed", guard, 0);
        check(idx == n, "R1", "bytes taken", idx, n);
        tx_valid = 1'b0;
        op_mode  = mode;
        repeat (3) begin
            @(negedge clk);
            check(!line_oe && tx_ready, "R6", "idle after packet",
                  {line_oe, tx_ready}, 2'b01);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n    = 1'b0;
        bit_en   = 1'b0;
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        op_mode  = 2'b00;
        repeat (4) @(negedge clk);
        // R12: reset state
        check({line_dp, line_dm, line_oe, tx_ready} == 4'b1001, "R12", "reset outputs",
              {line_dp, line_dm, line_oe, tx_ready}, 4'b1001);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: long runs of ones (R4)
        pkt[0] = 8'hFF; pkt[1] = 8'hFF;
        run_packet(2, 2'b00);
        // Directed: stuffed bit right before end-of-packet (R4)
        pkt[0] = 8'hFC;
        run_packet(1, 2'b00);
        // Directed: raw mode (R9)
        pkt[0] = 8'hA5; pkt[1] = 8'hFF;
        run_packet(2, 2'b10);
        // Directed: driver disabled (R8)
        pkt[0] = 8'hFF; pkt[1] = 8'h00;
        run_packet(2, 2'b01);
        // Directed: reserved mode acts as normal (R7)
        pkt[0] = 8'h7E; pkt[1] = 8'h3F;
        run_packet(2, 2'b11);

        // Constrained random packets (R1 R3 R5)
        for (int p = 0; p < 40; p++) begin
            int n = 1 + ($urandom % 6);
            for (int b = 0; b < n; b++)
                pkt[b] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            run_packet(n, 2'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule